// File: doc/BRIEF.md
# Modem Control Handshake Sequencer

This block drives the control lines of an RS-232 port through the steps that bring up a line, keep it up while a message goes out, and tear it down again. When a connect request arrives it raises DTR (in modem mode only after the ring indicator has been seen), waits for DSR, raises RTS, and then waits for both CTS and DCD before the line counts as established. While the line is up, characters may go out only when the transmitter is ready. When the sender reports that the last character has gone out, both lines are held a little longer and then dropped.

Every wait is bounded. The limits are counted in ticks of a 1 ms strobe: the whole bring-up, the CTS/DCD wait, the wait for the transmitter on a pending character, and the hold time after the last character. An expired bring-up or character wait drops DTR and RTS and raises a fault flag. The fault flag stays up until the requester withdraws. If DSR is lost while the line is up, the block drops both lines and returns to its initial state without reporting a fault. The serial data path and dialing are handled elsewhere.

Top module: `modem_link_seq`

## Requirements
- R1: After reset, dtr_out, rts_out, link_up, xmit_enable and link_fault are all 0.
- R2: With modem_sel=0, dtr_out rises after link_req without regard to ring_in, and rts_out stays 0 until dsr_in is seen at 1.
- R3: With modem_sel=1, dtr_out stays 0 after link_req until ring_in is seen at 1.
- R4: rts_out rises only after dsr_in has been seen at 1 with dtr_out high. link_up becomes 1 only once cts_in and dcd_in are both 1, and it is 1 only while dtr_out, rts_out, dsr_in and cts_in are all 1.
- R5: If CTS and DCD are not both present within TMO_HS ticks of RTS rising, link_fault goes to 1 and dtr_out and rts_out go to 0. After TMO_HS-1 ticks there is no fault yet.
- R6: If the line is not established within TMO_LINE ticks of leaving the idle state, link_fault goes to 1 and both control lines drop. After TMO_LINE-1 ticks there is no fault yet.
- R7: xmit_enable is 1 exactly when link_up and xmit_ready are both 1.
- R8: While the line is up, if char_waiting=1 and xmit_ready=0 hold for TMO_CHAR consecutive ticks, link_fault goes to 1 and both lines drop. A cycle with xmit_ready=1 restarts the count.
- R9: After last_char_sent, dtr_out and rts_out stay 1 for HOLD_TICKS-1 ticks and drop together on tick HOLD_TICKS without a fault. They then stay 0 until link_req has gone to 0.
- R10: Loss of dsr_in while the line is up drops dtr_out and rts_out without a fault and returns the block to its initial state; in modem mode a fresh ring_in is then needed before DTR rises again.
- R11: link_fault stays 1, with dtr_out and rts_out at 0, for as long as link_req stays 1, and it clears once link_req is 0.
- R12: A drop of cts_in while the line is up clears link_up but leaves dtr_out and rts_out at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_req | input | 1 | Request to bring up and hold a line |
| modem_sel | input | 1 | 1: modem mode (wait for ring), 0: direct connection |
| last_char_sent | input | 1 | Pulse: final character of the message has gone out |
| char_waiting | input | 1 | A character is pending for the transmitter |
| xmit_ready | input | 1 | Transmitter can accept a character |
| dsr_in | input | 1 | Data set ready from the far side |
| cts_in | input | 1 | Clear to send |
| dcd_in | input | 1 | Carrier detect |
| ring_in | input | 1 | Ring indicator |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| dtr_out | output | 1 | Data terminal ready |
| rts_out | output | 1 | Request to send |
| link_up | output | 1 | Line established |
| xmit_enable | output | 1 | A character may be sent now |
| link_fault | output | 1 | Timeout fault, held until link_req drops |

## Verification
The bench builds the block with TMO_LINE=40, TMO_HS=12, TMO_CHAR=15 and HOLD_TICKS=6 instead of the 30000/5000/7000/100 ms defaults. Each limit can then be approached one tick short and then crossed within a few hundred clock cycles. Because TMO_HS is well below TMO_LINE, the CTS/DCD timeout and the overall bring-up timeout can be triggered separately. The random loop draws tick counts on both sides of TMO_HS in both modes.

// File: rtl/modem_link_pkg.sv
package modem_link_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RING  = 3'd1,
        ST_DSR   = 3'd2,
        ST_CTS   = 3'd3,
        ST_UP    = 3'd4,
        ST_HOLD  = 3'd5,
        ST_DONE  = 3'd6,
        ST_FAULT = 3'd7
    } link_state_e;

    typedef struct packed {
        logic dtr;
        logic rts;
        logic fault;
    } line_drive_t;

    function automatic line_drive_t drive_of(link_state_e st);
        line_drive_t d;
        d.dtr   = (st == ST_DSR) || (st == ST_CTS) || (st == ST_UP) || (st == ST_HOLD);
        d.rts   = (st == ST_CTS) || (st == ST_UP) || (st == ST_HOLD);
        d.fault = (st == ST_FAULT);
        return d;
    endfunction

    function automatic logic in_bringup(link_state_e st);
        return (st == ST_RING) || (st == ST_DSR) || (st == ST_CTS);
    endfunction

    function automatic int unsigned cnt_width(int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/modem_link_timer.sv
module modem_link_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expired
);
    import modem_link_pkg::*;

    localparam int unsigned W = cnt_width(LIMIT);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && tick && (cnt != LIM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

endmodule

// File: rtl/modem_link_fsm.sv
module modem_link_fsm
    import modem_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        link_req,
    input  logic        modem_sel,
    input  logic        last_char_sent,
    input  logic        dsr_in,
    input  logic        cts_in,
    input  logic        dcd_in,
    input  logic        ring_in,
    input  logic        line_exp,
    input  logic        hs_exp,
    input  logic        char_exp,
    input  logic        hold_exp,
    output link_state_e state
);

    link_state_e st_n;

    always_comb begin
        st_n = state;
        unique case (state)
            ST_IDLE: begin
                if (link_req) st_n = modem_sel ? ST_RING : ST_DSR;
            end
            ST_RING: begin
                if (!link_req)     st_n = ST_IDLE;
                else if (line_exp) st_n = ST_FAULT;
                else if (ring_in)  st_n = ST_DSR;
            end
            ST_DSR: begin
                if (!link_req)     st_n = ST_IDLE;
                else if (line_exp) st_n = ST_FAULT;
                else if (dsr_in)   st_n = ST_CTS;
            end
            ST_CTS: begin
                if (!link_req)                  st_n = ST_IDLE;
                else if (line_exp || hs_exp)    st_n = ST_FAULT;
                else if (dsr_in && cts_in && dcd_in) st_n = ST_UP;
            end
            ST_UP: begin
                if (!dsr_in || !link_req) st_n = ST_IDLE;
                else if (char_exp)        st_n = ST_FAULT;
                else if (last_char_sent)  st_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (!dsr_in)       st_n = ST_IDLE;
                else if (hold_exp) st_n = ST_DONE;
            end
            ST_DONE: begin
                if (!link_req) st_n = ST_IDLE;
            end
            ST_FAULT: begin
                if (!link_req) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= st_n;
    end

endmodule

// File: rtl/modem_link_seq.sv
module modem_link_seq
    import modem_link_pkg::*;
#(
    parameter int unsigned TMO_LINE   = 30000,
    parameter int unsigned TMO_HS     = 5000,
    parameter int unsigned TMO_CHAR   = 7000,
    parameter int unsigned HOLD_TICKS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic link_req,
    input  logic modem_sel,
    input  logic last_char_sent,
    input  logic char_waiting,
    input  logic xmit_ready,
    input  logic dsr_in,
    input  logic cts_in,
    input  logic dcd_in,
    input  logic ring_in,
    input  logic ms_tick,
    output logic dtr_out,
    output logic rts_out,
    output logic link_up,
    output logic xmit_enable,
    output logic link_fault
);

    localparam int NT = 4;
    localparam int unsigned LIMITS [NT] = '{TMO_LINE, TMO_HS, TMO_CHAR, HOLD_TICKS};

    link_state_e state;
    line_drive_t drv;
    logic [NT-1:0] t_run, t_clr, t_exp;

    assign t_run[0] = in_bringup(state);
    assign t_clr[0] = (state == ST_IDLE);
    assign t_run[1] = (state == ST_CTS);
    assign t_clr[1] = !t_run[1];
    assign t_run[2] = (state == ST_UP) && char_waiting && !xmit_ready;
    assign t_clr[2] = !t_run[2];
    assign t_run[3] = (state == ST_HOLD);
    assign t_clr[3] = !t_run[3];

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        modem_link_timer #(.LIMIT(LIMITS[i])) u_tmr (
            .clk     (clk),
            .rst     (rst),
            .clr     (t_clr[i]),
            .run     (t_run[i]),
            .tick    (ms_tick),
            .expired (t_exp[i])
        );
    end

    modem_link_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .link_req       (link_req),
        .modem_sel      (modem_sel),
        .last_char_sent (last_char_sent),
        .dsr_in         (dsr_in),
        .cts_in         (cts_in),
        .dcd_in         (dcd_in),
        .ring_in        (ring_in),
        .line_exp       (t_exp[0]),
        .hs_exp         (t_exp[1]),
        .char_exp       (t_exp[2]),
        .hold_exp       (t_exp[3]),
        .state          (state)
    );

    assign drv         = drive_of(state);
    assign dtr_out     = drv.dtr;
    assign rts_out     = drv.rts;
    assign link_fault  = drv.fault;
    assign link_up     = ((state == ST_UP) || (state == ST_HOLD)) && dsr_in && cts_in;
    assign xmit_enable = link_up && xmit_ready;

endmodule

// File: rtl/modem_link_chk.sv
module modem_link_chk (
    input logic clk,
    input logic rst,
    input logic link_req,
    input logic modem_sel,
    input logic xmit_ready,
    input logic dsr_in,
    input logic cts_in,
    input logic ring_in,
    input logic dtr_out,
    input logic rts_out,
    input logic link_up,
    input logic xmit_enable,
    input logic link_fault
);

    a_r4_rts_needs_dtr: assert property (@(posedge clk) disable iff (rst)
        rts_out |-> dtr_out);

    a_r4_up_all_lines: assert property (@(posedge clk) disable iff (rst)
        link_up |-> (dtr_out && rts_out && dsr_in && cts_in));

    a_r4_rts_after_dsr: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_out) |-> $past(dsr_in));

    a_r3_dtr_after_ring: assert property (@(posedge clk) disable iff (rst)
        ($rose(dtr_out) && modem_sel && $past(modem_sel)) |-> $past(ring_in));

    a_r7_enable_gated: assert property (@(posedge clk) disable iff (rst)
        xmit_enable |-> (link_up && xmit_ready));

    a_r9_drop_together: assert property (@(posedge clk) disable iff (rst)
        $fell(rts_out) |-> !dtr_out);

    a_r11_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        link_fault |-> (!dtr_out && !rts_out));

    a_r11_fault_held: assert property (@(posedge clk) disable iff (rst)
        (link_fault && link_req) |=> link_fault);

endmodule

bind modem_link_seq modem_link_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .link_req    (link_req),
    .modem_sel   (modem_sel),
    .xmit_ready  (xmit_ready),
    .dsr_in      (dsr_in),
    .cts_in      (cts_in),
    .ring_in     (ring_in),
    .dtr_out     (dtr_out),
    .rts_out     (rts_out),
    .link_up     (link_up),
    .xmit_enable (xmit_enable),
    .link_fault  (link_fault)
);

// File: tb/modem_link_seq_test.sv
module modem_link_seq_test;

    localparam int TL = 40;
    localparam int TH = 12;
    localparam int TC = 15;
    localparam int HT = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_req = 0, modem_sel = 0, last_char_sent = 0, char_waiting = 0;
    logic xmit_ready = 0, dsr_in = 0, cts_in = 0, dcd_in = 0, ring_in = 0, ms_tick = 0;
    logic dtr_out, rts_out, link_up, xmit_enable, link_fault;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    modem_link_seq #(.TMO_LINE(TL), .TMO_HS(TH), .TMO_CHAR(TC), .HOLD_TICKS(HT)) uut (
        .clk(clk), .rst(rst), .link_req(link_req), .modem_sel(modem_sel),
        .last_char_sent(last_char_sent), .char_waiting(char_waiting),
        .xmit_ready(xmit_ready), .dsr_in(dsr_in), .cts_in(cts_in), .dcd_in(dcd_in),
        .ring_in(ring_in), .ms_tick(ms_tick), .dtr_out(dtr_out), .rts_out(rts_out),
        .link_up(link_up), .xmit_enable(xmit_enable), .link_fault(link_fault)
    );

    function automatic logic exp_timeout(int ticks, int limit);
        return ticks >= limit;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        link_req = 0; dsr_in = 0; cts_in = 0; dcd_in = 0; ring_in = 0;
        char_waiting = 0; xmit_ready = 0; last_char_sent = 0;
        settle();
    endtask

    task automatic to_cts_wait(logic modem);
        @(negedge clk);
        modem_sel = modem; link_req = 1;
        settle();
        if (modem) begin
            @(negedge clk) ring_in = 1;
            @(negedge clk) ring_in = 0;
            settle();
        end
        @(negedge clk) dsr_in = 1;
        settle();
    endtask

    task automatic bring_up(logic modem);
        to_cts_wait(modem);
        @(negedge clk) begin cts_in = 1; dcd_in = 1; end
        settle();
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1: actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        settle();
        // R1 reset state
        chk("R1", "dtr", dtr_out, 0);
        chk("R1", "rts", rts_out, 0);
        chk("R1", "link_up", link_up, 0);
        chk("R1", "xmit_enable", xmit_enable, 0);
        chk("R1", "fault", link_fault, 0);

        // R2 direct mode, ring ignored
        @(negedge clk) begin modem_sel = 0; ring_in = 0; link_req = 1; end
        settle();
        chk("R2", "dtr direct", dtr_out, 1);
        chk("R2", "rts before dsr", rts_out, 0);
        @(negedge clk) ring_in = 1;
        settle();
        chk("R2", "rts ring ignored", rts_out, 0);
        @(negedge clk) begin ring_in = 0; dsr_in = 1; end
        settle();
        chk("R4", "rts after dsr", rts_out, 1);
        chk("R4", "no link without cts", link_up, 0);
        @(negedge clk) cts_in = 1;
        settle();
        chk("R4", "no link without dcd", link_up, 0);
        @(negedge clk) dcd_in = 1;
        settle();
        chk("R4", "link up", link_up, 1);
        // R7
        chk("R7", "enable w/o ready", xmit_enable, 0);
        @(negedge clk) xmit_ready = 1;
        @(negedge clk);
        chk("R7", "enable with ready", xmit_enable, 1);
        // R12
        @(negedge clk) cts_in = 0;
        @(negedge clk);
        chk("R12", "link_up on cts loss", link_up, 0);
        chk("R12", "rts kept", rts_out, 1);
        chk("R12", "dtr kept", dtr_out, 1);
        chk("R7", "enable on cts loss", xmit_enable, 0);
        @(negedge clk) cts_in = 1;
        settle();
        // R9 hold then release
        @(negedge clk) last_char_sent = 1;
        @(negedge clk) last_char_sent = 0;
        tick(HT - 1);
        chk("R9", "rts during hold", rts_out, 1);
        chk("R9", "dtr during hold", dtr_out, 1);
        tick(1);
        chk("R9", "rts dropped", rts_out, 0);
        chk("R9", "dtr dropped", dtr_out, 0);
        chk("R9", "no fault", link_fault, 0);
        tick(2);
        chk("R9", "stays released", dtr_out, 0);
        go_idle();

        // R3 modem mode waits for ring
        @(negedge clk) begin modem_sel = 1; link_req = 1; end
        settle();
        tick(3);
        chk("R3", "dtr before ring", dtr_out, 0);
        @(negedge clk) ring_in = 1;
        @(negedge clk) ring_in = 0;
        settle();
        chk("R3", "dtr after ring", dtr_out, 1);
        go_idle();

        // R6 bring-up timeout
        @(negedge clk) begin modem_sel = 0; link_req = 1; end
        settle();
        tick(TL - 1);
        chk("R6", "no fault yet", link_fault, 0);
        chk("R6", "dtr still up", dtr_out, 1);
        tick(1);
        chk("R6", "fault", link_fault, 1);
        chk("R6", "dtr dropped", dtr_out, 0);
        tick(2);
        chk("R11", "fault held", link_fault, 1);
        chk("R11", "dtr low in fault", dtr_out, 0);
        go_idle();
        chk("R11", "fault cleared", link_fault, 0);

        // R5 handshake timeout
        to_cts_wait(0);
        tick(TH - 1);
        chk("R5", "no fault yet", link_fault, 0);
        tick(1);
        chk("R5", "fault", link_fault, 1);
        chk("R5", "rts dropped", rts_out, 0);
        go_idle();

        // R8 character wait
        bring_up(0);
        @(negedge clk) begin char_waiting = 1; xmit_ready = 0; end
        tick(TC - 1);
        chk("R8", "no fault yet", link_fault, 0);
        @(negedge clk) xmit_ready = 1;
        @(negedge clk) xmit_ready = 0;
        tick(TC - 1);
        chk("R8", "restart by ready", link_fault, 0);
        tick(1);
        chk("R8", "fault", link_fault, 1);
        chk("R8", "dtr dropped", dtr_out, 0);
        go_idle();

        // R10 dsr loss in modem mode
        bring_up(1);
        chk("R10", "up before loss", link_up, 1);
        @(negedge clk) dsr_in = 0;
        settle();
        chk("R10", "dtr dropped", dtr_out, 0);
        chk("R10", "rts dropped", rts_out, 0);
        chk("R10", "no fault", link_fault, 0);
        @(negedge clk) ring_in = 1;
        @(negedge clk) ring_in = 0;
        settle();
        chk("R10", "rearmed by ring", dtr_out, 1);
        go_idle();

        // random handshake wait lengths, R5
        for (int it = 0; it < 12; it++) begin
            logic m;
            int n;
            logic f;
            m = 1'($urandom % 2);
            n = int'($urandom % (TH + 4));
            f = exp_timeout(n, TH);
            to_cts_wait(m);
            tick(n);
            chk("R5", "random fault", link_fault, f);
            chk("R5", "random rts", rts_out, !f);
            go_idle();
        end

        report();
        $finish;
    end

endmodule